// File: doc/BRIEF.md
# Multi-Channel UART Sleep Controller

This block decides when a UART with several channels may stop its oscillator, and when it must start it again. Each channel supplies its idle facts: whether software allows sleep, whether an interrupt is pending, whether both FIFOs are empty, the level on its RX pin and whether that pin is in infrared mode, its baud divisor value, its four modem-change status bits, and a strobe for writes to its transmit holding register. The controller enters sleep only when every channel is idle at the same time. It leaves sleep as soon as any channel stops being idle.

After a wake, the oscillator enable stays on for a settle count that software programs. Once that count has run down, the controller goes back to sleep by itself if every channel is idle again. Each channel can ask to be told about wakes. A wake then sets that channel's wake interrupt, and the interrupt stays set until software reads the channel's interrupt status. The RX pins are asynchronous, so they pass through a two-flop synchronizer before they take part in the idle decision.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: While reset is asserted, `asleep_o` is 0, `osc_en_o` is 1 and every bit of `wake_irq_o` is 0.
- R2: When every channel is idle and the settle count has expired, `asleep_o` goes to 1 at the next clock edge. A channel is idle when all of these hold: its sleep enable is 1, its pending-interrupt bit is 0, both of its FIFO-empty flags are 1, it has no transmit-holding write this cycle, its synchronized RX level is idle, its four modem-change bits are all 0, and its divisor is non-zero.
- R3: A single channel that is not idle keeps the whole controller awake, even when every other channel is idle.
- R4: A divisor of zero on any channel prevents sleep. If the controller is already asleep, a zero divisor wakes it at the next edge.
- R5: The idle RX level is 1 when the channel's infrared-mode bit is 0, and 0 when that bit is 1. A change on an RX pin affects the sleep decision at the third clock edge after it is applied, because of the two-flop synchronizer.
- R6: While asleep, any of the following on any channel clears `asleep_o` at the next edge: sleep enable dropping to 0, an interrupt becoming pending, a transmit-holding write, or a non-zero modem-change bit.
- R7: After a wake with settle count L, the controller stays awake for at least L+1 cycles. If every channel is idle throughout, it returns to sleep at exactly that point, with no action from software.
- R8: On a wake, `wake_irq_o[c]` is set for each channel c whose `wake_ind_en_i[c]` is 1. No other bits are set, and no bit is set at any other time.
- R9: A 1 on `isr_rd_i[c]` clears `wake_irq_o[c]` at the next edge. If a wake happens in the same cycle, the set takes priority over the clear.
- R10: `osc_en_o` is 0 exactly while `asleep_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-running controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| settle_len_i | input | SETTLE_W | Number of cycles the controller is held awake after a wake |
| sleep_en_i | input | NCH | Per-channel sleep enable |
| irq_pend_i | input | NCH | Per-channel interrupt pending |
| rx_empty_i | input | NCH | Per-channel RX FIFO empty |
| tx_empty_i | input | NCH | Per-channel TX FIFO and shifter empty |
| rx_pin_i | input | NCH | Asynchronous RX pin levels |
| ir_mode_i | input | NCH | Per-channel infrared mode (idle RX level is low) |
| divisor_i | input | NCH*DIV_W | Per-channel baud divisors; channel c uses bits [c*DIV_W +: DIV_W] |
| modem_chg_i | input | NCH*4 | Per-channel modem-change bits; channel c uses bits [c*4 +: 4] |
| thr_wr_i | input | NCH | Per-channel transmit holding register write strobe |
| wake_ind_en_i | input | NCH | Per-channel enable for the wake indicator interrupt |
| isr_rd_i | input | NCH | Per-channel interrupt status read strobe |
| osc_en_o | output | 1 | Oscillator enable |
| asleep_o | output | 1 | Sleep status |
| wake_irq_o | output | NCH | Per-channel wake indicator interrupt |

## Verification
The bench builds the controller with three channels, 8-bit divisors and a 4-bit settle counter, with the settle count set to 3. Three channels let the bench hold the middle channel non-idle while both of its neighbours are idle, so the cross-channel AND is tested with the blocking channel in the middle. A settle count of 3 is short enough that the exact cycle of automatic re-entry can be checked. The bench enables the wake indicator on a non-contiguous subset of channels, which shows that the indicator bits are set per channel. It also times the RX synchronizer delay in both RX polarities.

// File: rtl/uart_sleep_pkg.sv
package uart_sleep_pkg;
    typedef enum logic [0:0] {
        PWR_RUN  = 1'b0,
        PWR_DOZE = 1'b1
    } pwr_state_e;

    localparam int MODEM_BITS = 4;
endpackage

// File: rtl/usc_rx_sync.sv
module usc_rx_sync #(
    parameter int NCH = 2
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] pin_i,
    output logic [NCH-1:0] pin_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_sync
        logic [1:0] stg_d, stg_q;

        always_comb begin
            stg_d = {stg_q[0], pin_i[g]};
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) stg_q <= 2'b11;
            else         stg_q <= stg_d;
        end

        assign pin_o[g] = stg_q[1];
    end
endmodule

// File: rtl/usc_idle_eval.sv
module usc_idle_eval #(
    parameter int NCH   = 2,
    parameter int DIV_W = 16,
    parameter int MDM_W = 4
) (
    input  logic [NCH-1:0]       sleep_en_i,
    input  logic [NCH-1:0]       irq_pend_i,
    input  logic [NCH-1:0]       rx_empty_i,
    input  logic [NCH-1:0]       tx_empty_i,
    input  logic [NCH-1:0]       rx_sync_i,
    input  logic [NCH-1:0]       ir_mode_i,
    input  logic [NCH*DIV_W-1:0] divisor_i,
    input  logic [NCH*MDM_W-1:0] modem_chg_i,
    input  logic [NCH-1:0]       thr_wr_i,
    output logic [NCH-1:0]       ch_idle_o,
    output logic                 all_idle_o
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic rx_quiet, div_ok, mdm_quiet;

        // The idle RX level is the inverse of the infrared-mode bit.
        assign rx_quiet  = rx_sync_i[g] ^ ir_mode_i[g];
        assign div_ok    = |divisor_i[g*DIV_W +: DIV_W];
        assign mdm_quiet = ~|modem_chg_i[g*MDM_W +: MDM_W];

        assign ch_idle_o[g] = sleep_en_i[g] & ~irq_pend_i[g] & rx_empty_i[g]
                            & tx_empty_i[g] & ~thr_wr_i[g] & rx_quiet
                            & div_ok & mdm_quiet;
    end

    assign all_idle_o = &ch_idle_o;
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
    import uart_sleep_pkg::*;
#(
    parameter int NCH      = 2,
    parameter int DIV_W    = 16,
    parameter int SETTLE_W = 8
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [SETTLE_W-1:0]              settle_len_i,
    input  logic [NCH-1:0]                   sleep_en_i,
    input  logic [NCH-1:0]                   irq_pend_i,
    input  logic [NCH-1:0]                   rx_empty_i,
    input  logic [NCH-1:0]                   tx_empty_i,
    input  logic [NCH-1:0]                   rx_pin_i,
    input  logic [NCH-1:0]                   ir_mode_i,
    input  logic [NCH*DIV_W-1:0]             divisor_i,
    input  logic [NCH*MODEM_BITS-1:0]        modem_chg_i,
    input  logic [NCH-1:0]                   thr_wr_i,
    input  logic [NCH-1:0]                   wake_ind_en_i,
    input  logic [NCH-1:0]                   isr_rd_i,
    output logic                             osc_en_o,
    output logic                             asleep_o,
    output logic [NCH-1:0]                   wake_irq_o
);
    localparam logic [SETTLE_W-1:0] CNT_ONE = {{(SETTLE_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        pwr_state_e          st;
        logic [SETTLE_W-1:0] cnt;
        logic [NCH-1:0]      wirq;
    } ctl_t;

    logic [NCH-1:0] rx_sync;
    logic [NCH-1:0] ch_idle;
    logic           all_idle;
    logic           wake_set;
    ctl_t           ctl_d, ctl_q;

    usc_rx_sync #(.NCH(NCH)) i_rx_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (rx_pin_i),
        .pin_o  (rx_sync)
    );

    usc_idle_eval #(.NCH(NCH), .DIV_W(DIV_W), .MDM_W(MODEM_BITS)) i_idle (
        .sleep_en_i  (sleep_en_i),
        .irq_pend_i  (irq_pend_i),
        .rx_empty_i  (rx_empty_i),
        .tx_empty_i  (tx_empty_i),
        .rx_sync_i   (rx_sync),
        .ir_mode_i   (ir_mode_i),
        .divisor_i   (divisor_i),
        .modem_chg_i (modem_chg_i),
        .thr_wr_i    (thr_wr_i),
        .ch_idle_o   (ch_idle),
        .all_idle_o  (all_idle)
    );

    always_comb begin
        ctl_d    = ctl_q;
        wake_set = 1'b0;
        unique case (ctl_q.st)
            PWR_DOZE: begin
                if (!all_idle) begin
                    ctl_d.st  = PWR_RUN;
                    ctl_d.cnt = settle_len_i;
                    wake_set  = 1'b1;
                end
            end
            PWR_RUN: begin
                if (ctl_q.cnt != '0)  ctl_d.cnt = ctl_q.cnt - CNT_ONE;
                else if (all_idle)    ctl_d.st  = PWR_DOZE;
            end
            default: ctl_d.st = PWR_RUN;
        endcase
        // A wake sets the indicator; a status read only clears it when no wake coincides.
        ctl_d.wirq = (ctl_q.wirq & ~isr_rd_i) | ({NCH{wake_set}} & wake_ind_en_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q.st   <= PWR_RUN;
            ctl_q.cnt  <= '0;
            ctl_q.wirq <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign asleep_o   = (ctl_q.st == PWR_DOZE);
    assign osc_en_o   = (ctl_q.st != PWR_DOZE);
    assign wake_irq_o = ctl_q.wirq;
endmodule

// File: rtl/uart_sleep_ctrl_chk.sv
module uart_sleep_ctrl_chk #(
    parameter int NCH      = 2,
    parameter int DIV_W    = 16,
    parameter int SETTLE_W = 8
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic [SETTLE_W-1:0]   settle_len_i,
    input logic [NCH-1:0]        sleep_en_i,
    input logic [NCH-1:0]        irq_pend_i,
    input logic [NCH-1:0]        rx_empty_i,
    input logic [NCH-1:0]        tx_empty_i,
    input logic [NCH*DIV_W-1:0]  divisor_i,
    input logic [NCH*4-1:0]      modem_chg_i,
    input logic [NCH-1:0]        thr_wr_i,
    input logic [NCH-1:0]        wake_ind_en_i,
    input logic [NCH-1:0]        isr_rd_i,
    input logic                  asleep_o,
    input logic [NCH-1:0]        wake_irq_o
);
    localparam int CW = SETTLE_W + 2;

    logic [CW-1:0]  run_cnt;
    logic [NCH-1:0] div_zero;

    for (genvar g = 0; g < NCH; g++) begin : g_dz
        assign div_zero[g] = (divisor_i[g*DIV_W +: DIV_W] == '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)               run_cnt <= '1;
        else if (asleep_o)         run_cnt <= '0;
        else if (run_cnt != '1)    run_cnt <= run_cnt + CW'(1);
    end

    a_r2_entry_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(asleep_o) |-> (&$past(sleep_en_i)) && (&$past(tx_empty_i))
                         && (&$past(rx_empty_i)) && ($past(irq_pend_i) == '0)
                         && ($past(thr_wr_i) == '0));

    a_r4_zero_div_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (asleep_o && (div_zero != '0)) |=> !asleep_o);

    a_r6_cause_wakes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (asleep_o && ((thr_wr_i != '0) || !(&sleep_en_i) || (irq_pend_i != '0)
                      || (modem_chg_i != '0))) |=> !asleep_o);

    a_r7_settle_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(asleep_o) |-> (run_cnt > CW'(settle_len_i)));

    a_r8_wake_sets_ind: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(asleep_o) |-> ((wake_irq_o & $past(wake_ind_en_i)) == $past(wake_ind_en_i)));

    a_r8_set_only_on_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((wake_irq_o & ~$past(wake_irq_o)) != '0) |-> $fell(asleep_o));

    a_r9_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$fell(asleep_o) |-> ((wake_irq_o & $past(isr_rd_i)) == '0));
endmodule

bind uart_sleep_ctrl uart_sleep_ctrl_chk #(
    .NCH(NCH), .DIV_W(DIV_W), .SETTLE_W(SETTLE_W)
) i_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .settle_len_i  (settle_len_i),
    .sleep_en_i    (sleep_en_i),
    .irq_pend_i    (irq_pend_i),
    .rx_empty_i    (rx_empty_i),
    .tx_empty_i    (tx_empty_i),
    .divisor_i     (divisor_i),
    .modem_chg_i   (modem_chg_i),
    .thr_wr_i      (thr_wr_i),
    .wake_ind_en_i (wake_ind_en_i),
    .isr_rd_i      (isr_rd_i),
    .asleep_o      (asleep_o),
    .wake_irq_o    (wake_irq_o)
);

// File: tb/test_uart_sleep_ctrl.sv
module test_uart_sleep_ctrl;
    localparam int NCH = 3, DIV_W = 8, SETTLE_W = 4, MW = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic                 rst_n;
    logic [SETTLE_W-1:0]  settle;
    logic [NCH-1:0]       sleep_en, irq_pend, rx_empty, tx_empty, rx_pin, ir_mode;
    logic [NCH-1:0]       thr_wr, ind_en, isr_rd;
    logic [NCH*DIV_W-1:0] divisor;
    logic [NCH*MW-1:0]    modem_chg;
    logic                 osc_en, asleep;
    logic [NCH-1:0]       wirq;

    uart_sleep_ctrl #(.NCH(NCH), .DIV_W(DIV_W), .SETTLE_W(SETTLE_W)) i_uart_sleep_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .settle_len_i(settle), .sleep_en_i(sleep_en),
        .irq_pend_i(irq_pend), .rx_empty_i(rx_empty), .tx_empty_i(tx_empty),
        .rx_pin_i(rx_pin), .ir_mode_i(ir_mode), .divisor_i(divisor),
        .modem_chg_i(modem_chg), .thr_wr_i(thr_wr), .wake_ind_en_i(ind_en),
        .isr_rd_i(isr_rd), .osc_en_o(osc_en), .asleep_o(asleep), .wake_irq_o(wirq)
    );

    int n_run = 0, n_fail = 0;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    // Behavioural reference model, advanced on each rising edge.
    bit           m_asleep;
    int           m_cnt;
    bit [NCH-1:0] m_irq, m_rx1, m_rxs;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_asleep = 0; m_cnt = 0; m_irq = '0; m_rx1 = '1; m_rxs = '1;
        end else begin
            bit idle, woke;
            idle = 1; woke = 0;
            for (int c = 0; c < NCH; c++) begin
                if (!sleep_en[c] || irq_pend[c] || !rx_empty[c] || !tx_empty[c] || thr_wr[c]) idle = 0;
                if (m_rxs[c] != !ir_mode[c]) idle = 0;
                if (modem_chg[c*MW +: MW] != 0) idle = 0;
                if (divisor[c*DIV_W +: DIV_W] == 0) idle = 0;
            end
            if (m_asleep) begin
                if (!idle) begin m_asleep = 0; m_cnt = settle; woke = 1; end
            end else if (m_cnt > 0) m_cnt--;
            else if (idle) m_asleep = 1;
            for (int c = 0; c < NCH; c++) begin
                if (woke && ind_en[c]) m_irq[c] = 1;
                else if (isr_rd[c])    m_irq[c] = 0;
            end
            m_rxs = m_rx1;
            m_rx1 = rx_pin;
        end
    end

    always @(negedge clk) begin
        if (rst_n) chk("model R10", {asleep, osc_en, wirq}, {m_asleep, !m_asleep, m_irq});
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; settle = 4'd3; sleep_en = '0; irq_pend = '0; rx_empty = '1; tx_empty = '1;
        rx_pin = '1; ir_mode = '0; divisor = {8'd5, 8'd3, 8'd1}; modem_chg = '0;
        thr_wr = '0; ind_en = 3'b101; isr_rd = '0;
        wait_n(3);
        chk("R1 asleep", asleep, 0); chk("R1 osc_en", osc_en, 1); chk("R1 wirq", wirq, 0);
        rst_n = 1;

        // R3: middle channel busy blocks sleep
        tx_empty = 3'b101; sleep_en = '1;
        wait_n(10); chk("R3 blocked", asleep, 0);
        tx_empty = '1;
        wait_n(6); chk("R2 asleep", asleep, 1); chk("R10 osc off", osc_en, 0);

        // R6/R8: transmit write wakes, indicator on channels 0 and 2
        thr_wr = 3'b100; wait_n(1); thr_wr = '0;
        chk("R6 thr wake", asleep, 0); chk("R8 ind", wirq, 3'b101); chk("R10 osc on", osc_en, 1);
        wait_n(3); chk("R7 still settling", asleep, 0);
        wait_n(1); chk("R7 auto reenter", asleep, 1);

        // R9: read clears channel 0 only
        isr_rd = 3'b001; wait_n(1); isr_rd = '0;
        chk("R9 clear", wirq, 3'b100);

        // R4: zero divisor wakes and blocks
        divisor[15:8] = '0; wait_n(1); chk("R4 wake", asleep, 0);
        wait_n(10); chk("R4 blocked", asleep, 0);
        divisor[15:8] = 8'd7; wait_n(6); chk("R4 restored", asleep, 1);
        isr_rd = '1; wait_n(1); isr_rd = '0; chk("R9 clear all", wirq, 0);

        // R5: infrared polarity and synchronizer delay
        ir_mode[1] = 1'b1; wait_n(1); chk("R5 ir high not idle", asleep, 0);
        wait_n(8); chk("R5 ir high blocks", asleep, 0);
        rx_pin[1] = 1'b0; wait_n(2); chk("R5 sync delay", asleep, 0);
        wait_n(1); chk("R5 ir low idle", asleep, 1);
        ir_mode[1] = 1'b0; rx_pin[1] = 1'b1; wait_n(1); chk("R5 normal low wakes", asleep, 0);
        wait_n(10); chk("R5 normal high idle", asleep, 1);

        // R6: modem change, pending interrupt, sleep disable
        modem_chg[2*MW+1] = 1'b1; wait_n(1); modem_chg = '0; chk("R6 modem", asleep, 0);
        wait_n(10); chk("R6 modem resleep", asleep, 1);
        irq_pend[0] = 1'b1; wait_n(1); chk("R6 irq", asleep, 0);
        wait_n(6); chk("R6 irq holds", asleep, 0);
        irq_pend[0] = 1'b0; wait_n(10); chk("R6 irq resleep", asleep, 1);
        sleep_en[2] = 1'b0; wait_n(1); chk("R6 disable", asleep, 0);
        wait_n(8); chk("R2 needs enable", asleep, 0);
        sleep_en[2] = 1'b1; wait_n(10); chk("R7 resleep", asleep, 1);

        // R9: set wins over a coincident read
        isr_rd = '1; wait_n(1); isr_rd = '0; chk("R9 pre-clear", wirq, 0);
        wait_n(1);
        thr_wr = 3'b001; isr_rd = 3'b001; wait_n(1); thr_wr = '0; isr_rd = '0;
        chk("R9 set wins", wirq, 3'b101);

        // R8: no indicator when not enabled
        wait_n(10); isr_rd = '1; wait_n(1); isr_rd = '0; ind_en = '0;
        chk("R8 asleep again", asleep, 1);
        thr_wr = 3'b010; wait_n(1); thr_wr = '0;
        chk("R8 no ind", wirq, 0); chk("R8 woke", asleep, 0);
        wait_n(4);
        finish_run();
    end
endmodule